// File: doc/BRIEF.md
# Vectored Interrupt Controller for an 8-bit Core

This block gathers interrupt requests for a small 8-bit processor and turns them into one vectored call request. Six sources feed it: an external pin, overflows of two timer/event counters, a merged USB event, and two serial interfaces. Each source has a request flag and an enable bit. Both live in two CPU-visible control registers. A single master enable bit and a "stack full" input from the core gate every source.

A two-state sequencer watches the gated requests. In state `IDLE`, if any source is eligible, it takes transition `LAUNCH`: it latches the vector of the lowest-addressed eligible source and moves to `CALLING`. In `CALLING`, `call_req` is raised. The sequencer leaves `CALLING` in one of two ways. On `call_ack` it takes transition `ACCEPT`: the serviced flag and the master enable are cleared in hardware, and it returns to `IDLE`. If the latched source stops being eligible before the core acknowledges, it takes transition `WITHDRAW` back to `IDLE`.

Four USB conditions merge into the one USB request: a host FIFO access, bus suspend, bus resume and bus reset. Per-FIFO sticky status bits and suspend/resume indication bits let firmware find the cause and clear it by writing ones.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0x00 and `call_req` is low.
- R2: Address 0 (control A) holds, from bit 0 up: master enable, external enable, timer0 enable, timer1 enable, external flag, timer0 flag, timer1 flag. Bit 7 always reads 0, and writes to it are ignored.
- R3: Address 1 (control B) holds: bit0 USB enable, bit1 serial 1 enable, bit2 serial 2 enable, bit4 USB flag, bit5 serial 1 flag, bit6 serial 2 flag. Bits 3 and 7 always read 0.
- R4: A one-cycle event pulse sets its flag at the next clock edge. If a CPU write to the same flag lands in the same cycle, the event wins and the flag reads 1.
- R5: `call_req` rises only when the master enable, the source enable and the source flag are all 1 and `stack_full` is 0. The vectors are: external 0x04, timer0 0x08, timer1 0x0C, USB 0x10, serial 1 0x14, serial 2 0x18.
- R6: When several sources are eligible, the lowest vector is presented. The other flags stay set.
- R7: A cycle with `call_req` and `call_ack` both high clears the serviced flag and the master enable. `call_req` is low in the following cycle.
- R8: If, while `call_req` is high and unacknowledged, `stack_full` rises or the source loses eligibility, `call_req` drops in the next cycle. No flag is cleared.
- R9: Any of a FIFO access, `usb_suspend`, `usb_resume` or `usb_bus_reset` sets the USB flag.
- R10: Address 2 reads the per-FIFO access bits (bit i = FIFO i; the upper bits read 0). They accumulate and stay set until firmware writes a 1 to them.
- R11: At address 3, bit0 is a sticky suspend indication and bit3 a sticky resume indication. Both are cleared by writing 1. The other bits read 0.
- R12: `call_vec` stays constant for as long as `call_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register select: 0 control A, 1 control B, 2 FIFO status, 3 bus status |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data of the selected register |
| ext_evt | input | 1 | External interrupt pulse |
| tmr0_ovf | input | 1 | Timer 0 overflow pulse |
| tmr1_ovf | input | 1 | Timer 1 overflow pulse |
| sio1_evt | input | 1 | Serial interface 1 pulse |
| sio2_evt | input | 1 | Serial interface 2 pulse |
| usb_fifo_acc | input | NUM_FIFO | Host access pulse for each FIFO |
| usb_suspend | input | 1 | Bus suspend pulse |
| usb_resume | input | 1 | Bus resume pulse |
| usb_bus_reset | input | 1 | Bus reset pulse |
| stack_full | input | 1 | Core call stack has no free entry |
| call_ack | input | 1 | Core accepts the presented call |
| call_req | output | 1 | Vectored call request |
| call_vec | output | 8 | Call target address |

## Verification
The bench builds the block with the default of four FIFO status bits. This exercises the zero-filled upper half of the FIFO status register and the reduction of several simultaneous FIFO pulses into one USB flag. Random register traffic runs with `stack_full` held high. This exposes the reserved-bit masks without any calls being raised. Directed sequences then open the stack and drive the priority, withdraw and event-beats-write cases.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NSRC = 6;

    // Source indices; the vector of index i is 4*(i+1), so order is priority.
    localparam int SRC_EXT  = 0;
    localparam int SRC_TMR0 = 1;
    localparam int SRC_TMR1 = 2;
    localparam int SRC_USB  = 3;
    localparam int SRC_SIO1 = 4;
    localparam int SRC_SIO2 = 5;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_CALLING = 1'b1
    } seq_state_t;

    function automatic logic [7:0] vector_of(input logic [2:0] idx);
        return {3'b000, idx + 3'd1, 2'b00};
    endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_a,
    input  logic            wr_b,
    input  logic [7:0]      wdata,
    input  logic [NSRC-1:0] set_evt,
    input  logic [NSRC-1:0] clr_src,
    input  logic            clr_emi,
    output logic            emi_q,
    output logic [NSRC-1:0] en_q,
    output logic [NSRC-1:0] flag_q
);
    localparam int HALF = NSRC / 2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       emi_q <= 1'b0;
        else if (clr_emi) emi_q <= 1'b0;
        else if (wr_a)    emi_q <= wdata[0];
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        localparam int EN_BIT = (i < HALF) ? i + 1 : i - HALF;
        localparam int FL_BIT = (i < HALF) ? i + 4 : i - HALF + 4;
        logic wr_hit;
        assign wr_hit = (i < HALF) ? wr_a : wr_b;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      en_q[i] <= 1'b0;
            else if (wr_hit) en_q[i] <= wdata[EN_BIT];
        end

        // Event set outranks both hardware clear and CPU write.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          flag_q[i] <= 1'b0;
            else if (set_evt[i]) flag_q[i] <= 1'b1;
            else if (clr_src[i]) flag_q[i] <= 1'b0;
            else if (wr_hit)     flag_q[i] <= wdata[FL_BIT];
        end
    end
endmodule

// File: rtl/usb_evt_merge.sv
module usb_evt_merge #(
    parameter int NUM_FIFO = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_FIFO-1:0] fifo_acc,
    input  logic                suspend,
    input  logic                resume,
    input  logic                bus_reset,
    input  logic                wr_stat,
    input  logic                wr_bus,
    input  logic [7:0]          wdata,
    output logic [NUM_FIFO-1:0] fifo_stat_q,
    output logic                susp_q,
    output logic                resm_q,
    output logic                usb_set
);
    logic [NUM_FIFO-1:0] w1c_mask;
    assign w1c_mask = wr_stat ? wdata[NUM_FIFO-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fifo_stat_q <= '0;
            susp_q      <= 1'b0;
            resm_q      <= 1'b0;
        end else begin
            fifo_stat_q <= (fifo_stat_q & ~w1c_mask) | fifo_acc;
            susp_q      <= suspend | (susp_q & ~(wr_bus & wdata[0]));
            resm_q      <= resume  | (resm_q & ~(wr_bus & wdata[3]));
        end
    end

    assign usb_set = (|fifo_acc) | suspend | resume | bus_reset;
endmodule

// File: rtl/irq_call_seq.sv
module irq_call_seq
    import irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            emi,
    input  logic [NSRC-1:0] en,
    input  logic [NSRC-1:0] flag,
    input  logic            stack_full,
    input  logic            call_ack,
    output logic            call_req,
    output logic [7:0]      call_vec,
    output logic [NSRC-1:0] clr_src,
    output logic            clr_emi
);
    seq_state_t state_q, state_d;
    logic [2:0] sel_q, sel_d;
    logic [2:0] pick;
    logic       any_ok;
    logic       held_ok;
    logic [NSRC-1:0] ok;

    assign ok = (emi && !stack_full) ? (en & flag) : '0;

    always_comb begin
        pick   = '0;
        any_ok = 1'b0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (ok[i]) begin
                pick   = 3'(i);
                any_ok = 1'b1;
            end
        end
    end

    assign held_ok = ok[sel_q];

    always_comb begin
        state_d = state_q;
        sel_d   = sel_q;
        unique case (state_q)
            ST_IDLE: begin
                if (any_ok) begin           // LAUNCH
                    state_d = ST_CALLING;
                    sel_d   = pick;
                end
            end
            ST_CALLING: begin
                if (call_ack)      state_d = ST_IDLE;   // ACCEPT
                else if (!held_ok) state_d = ST_IDLE;   // WITHDRAW
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            sel_q   <= sel_d;
        end
    end

    always_comb begin
        call_req = (state_q == ST_CALLING);
        call_vec = call_req ? vector_of(sel_q) : 8'h00;
        clr_emi  = call_req && call_ack;
        clr_src  = '0;
        if (clr_emi) clr_src[sel_q] = 1'b1;
    end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
    import irq_pkg::*;
#(
    parameter int NUM_FIFO = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          reg_addr,
    input  logic                reg_wr,
    input  logic [7:0]          reg_wdata,
    output logic [7:0]          reg_rdata,
    input  logic                ext_evt,
    input  logic                tmr0_ovf,
    input  logic                tmr1_ovf,
    input  logic                sio1_evt,
    input  logic                sio2_evt,
    input  logic [NUM_FIFO-1:0] usb_fifo_acc,
    input  logic                usb_suspend,
    input  logic                usb_resume,
    input  logic                usb_bus_reset,
    input  logic                stack_full,
    input  logic                call_ack,
    output logic                call_req,
    output logic [7:0]          call_vec
);
    logic            emi_q;
    logic [NSRC-1:0] en_q, flag_q, set_evt, clr_src;
    logic            clr_emi, usb_set, susp_q, resm_q;
    logic [NUM_FIFO-1:0] fifo_stat_q;

    assign set_evt = {sio2_evt, sio1_evt, usb_set, tmr1_ovf, tmr0_ovf, ext_evt};

    irq_flag_bank u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_a(reg_wr && reg_addr == 2'd0),
        .wr_b(reg_wr && reg_addr == 2'd1),
        .wdata(reg_wdata), .set_evt(set_evt),
        .clr_src(clr_src), .clr_emi(clr_emi),
        .emi_q(emi_q), .en_q(en_q), .flag_q(flag_q)
    );

    usb_evt_merge #(.NUM_FIFO(NUM_FIFO)) u_usb (
        .clk(clk), .rst_n(rst_n),
        .fifo_acc(usb_fifo_acc), .suspend(usb_suspend),
        .resume(usb_resume), .bus_reset(usb_bus_reset),
        .wr_stat(reg_wr && reg_addr == 2'd2),
        .wr_bus(reg_wr && reg_addr == 2'd3),
        .wdata(reg_wdata), .fifo_stat_q(fifo_stat_q),
        .susp_q(susp_q), .resm_q(resm_q), .usb_set(usb_set)
    );

    irq_call_seq u_seq (
        .clk(clk), .rst_n(rst_n),
        .emi(emi_q), .en(en_q), .flag(flag_q),
        .stack_full(stack_full), .call_ack(call_ack),
        .call_req(call_req), .call_vec(call_vec),
        .clr_src(clr_src), .clr_emi(clr_emi)
    );

    always_comb begin
        unique case (reg_addr)
            2'd0: reg_rdata = {1'b0, flag_q[2:0], en_q[2:0], emi_q};
            2'd1: reg_rdata = {1'b0, flag_q[5:3], 1'b0, en_q[5:3]};
            2'd2: reg_rdata = 8'(fifo_stat_q);
            default: reg_rdata = {4'b0000, resm_q, 2'b00, susp_q};
        endcase
    end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] reg_addr,
    input logic [7:0] reg_rdata,
    input logic       stack_full,
    input logic       call_ack,
    input logic       call_req,
    input logic [7:0] call_vec,
    input logic       emi_q
);
    AST_NO_CALL_STACK_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(call_req) |-> !$past(stack_full) && $past(emi_q)); // R5

    AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        call_req |-> (call_vec[1:0] == 2'b00 && call_vec >= 8'h04 && call_vec <= 8'h18)); // R5

    AST_ACK_DROPS_EMI: assert property (@(posedge clk) disable iff (!rst_n)
        (call_req && call_ack) |=> (!emi_q && !call_req)); // R7

    AST_VEC_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (call_req && $past(call_req)) |-> $stable(call_vec)); // R12

    AST_CTRL_A_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd0) |-> !reg_rdata[7]); // R2

    AST_CTRL_B_GAPS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd1) |-> (!reg_rdata[7] && !reg_rdata[3])); // R3
endmodule

bind vec_irq_ctrl irq_ctrl_chk chk_i (.*);

// File: tb/vec_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module vec_irq_ctrl_tb_top;
    localparam int NF = 4;
    logic clk = 1'b0, rst_n = 1'b0;
    logic [1:0] reg_addr = '0;
    logic reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic ext_evt = 0, tmr0_ovf = 0, tmr1_ovf = 0, sio1_evt = 0, sio2_evt = 0;
    logic [NF-1:0] usb_fifo_acc = '0;
    logic usb_suspend = 0, usb_resume = 0, usb_bus_reset = 0;
    logic stack_full = 0, call_ack = 0, call_req;
    logic [7:0] call_vec;
    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    vec_irq_ctrl #(.NUM_FIFO(NF)) dut_i (.*);

    function automatic logic [7:0] mask_a(input logic [7:0] w); return w & 8'h7F; endfunction
    function automatic logic [7:0] mask_b(input logic [7:0] w); return w & 8'h77; endfunction

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic tick(); @(posedge clk); @(negedge clk); endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a; #0.5; d = reg_rdata;
    endtask

    task automatic ack();
        call_ack = 1'b1; tick(); call_ack = 1'b0;
    endtask

    initial begin
        logic [7:0] d, w;
        logic [NF-1:0] acc_exp, m;
        void'($urandom(32'd4711));
        repeat (2) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        for (int a = 0; a < 4; a++) begin rd(2'(a), d); check("R1 reset reg", d, 8'h00); end
        check("R1 call_req idle", {7'b0, call_req}, 8'h00);

        // R2/R3 random register traffic, no calls possible
        stack_full = 1'b1;
        for (int i = 0; i < 40; i++) begin
            w = 8'($urandom());
            wr(2'd0, w); rd(2'd0, d); check("R2 ctrl A readback", d, mask_a(w));
            w = 8'($urandom());
            wr(2'd1, w); rd(2'd1, d); check("R3 ctrl B readback", d, mask_b(w));
            check("R5 no call while stack full", {7'b0, call_req}, 8'h00);
        end
        wr(2'd0, 8'h00); wr(2'd1, 8'h00);
        stack_full = 1'b0;

        // R10 random FIFO accesses accumulate; W1C
        acc_exp = '0;
        for (int i = 0; i < 30; i++) begin
            usb_fifo_acc = NF'($urandom()) & NF'($urandom());
            acc_exp |= usb_fifo_acc;
            tick();
        end
        usb_fifo_acc = '0;
        rd(2'd2, d); check("R10 fifo status accumulate", d, 8'(acc_exp));
        rd(2'd1, d); check("R9 fifo access sets usb flag", d & 8'h10, 8'h10);
        m = NF'($urandom());
        wr(2'd2, 8'hF0 | 8'(m));
        rd(2'd2, d); check("R10 fifo status w1c", d, 8'(acc_exp & ~m));
        wr(2'd2, 8'hFF); wr(2'd1, 8'h00);

        // R5/R7 timer1 call
        wr(2'd0, 8'h09);
        tmr1_ovf = 1; tick(); tmr1_ovf = 0;
        check("R4 flag set, no call yet", {7'b0, call_req}, 8'h00);
        tick();
        check("R5 timer1 call_req", {7'b0, call_req}, 8'h01);
        check("R5 timer1 vector", call_vec, 8'h0C);
        ack();
        check("R7 call_req drops after ack", {7'b0, call_req}, 8'h00);
        rd(2'd0, d); check("R7 flag and master cleared", d, 8'h08);

        // R6 priority, R9 suspend, R11
        wr(2'd1, 8'h01); wr(2'd0, 8'h0B);
        ext_evt = 1; tmr1_ovf = 1; usb_suspend = 1; tick();
        ext_evt = 0; tmr1_ovf = 0; usb_suspend = 0;
        tick();
        check("R6 lowest vector wins", call_vec, 8'h04);
        ack();
        rd(2'd0, d); check("R6 others stay pending", d, 8'h4A);
        wr(2'd0, 8'h4B); tick();
        check("R6 next vector timer1", call_vec, 8'h0C);
        ack();
        wr(2'd0, 8'h0B); tick();
        check("R9 suspend raises usb call", call_vec, 8'h10);
        ack();
        rd(2'd1, d); check("R7 usb flag cleared", d, 8'h01);
        rd(2'd3, d); check("R11 suspend indication", d, 8'h01);
        usb_resume = 1; tick(); usb_resume = 0;
        rd(2'd3, d); check("R11 resume indication", d, 8'h09);
        wr(2'd3, 8'h01);
        rd(2'd3, d); check("R11 w1c suspend only", d, 8'h08);
        wr(2'd3, 8'h08);
        usb_bus_reset = 1; tick(); usb_bus_reset = 0;
        rd(2'd1, d); check("R9 bus reset sets usb flag", d, 8'h11);
        wr(2'd1, 8'h00);

        // R8 stack gating and withdraw
        stack_full = 1;
        wr(2'd0, 8'h05);
        tmr0_ovf = 1; tick(); tmr0_ovf = 0;
        tick(); tick();
        check("R5 gated by stack_full", {7'b0, call_req}, 8'h00);
        stack_full = 0; tick();
        check("R5 call after stack frees", call_vec, 8'h08);
        stack_full = 1; tick();
        check("R8 withdraw on stack full", {7'b0, call_req}, 8'h00);
        rd(2'd0, d); check("R8 flag kept on withdraw", d, 8'h25);
        stack_full = 0; tick();
        check("R12 vector again", call_vec, 8'h08);
        tick();
        check("R12 vector held", call_vec, 8'h08);
        ack();

        // R4 event beats same-cycle write of 0
        reg_addr = 2'd0; reg_wdata = 8'h00; reg_wr = 1; ext_evt = 1;
        tick();
        reg_wr = 0; ext_evt = 0;
        rd(2'd0, d); check("R4 event wins over write", d, 8'h10);

        // serial 2 vector
        wr(2'd0, 8'h01); wr(2'd1, 8'h04);
        sio2_evt = 1; tick(); sio2_evt = 0; tick();
        check("R5 serial2 vector", call_vec, 8'h18);
        ack();
        rd(2'd1, d); check("R3 serial2 flag cleared", d, 8'h04);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule